// File: doc/BRIEF.md
# Buffer Writeback and Host Notification Unit

This unit moves packets that have landed in on-card receive buffers out to host memory. It also reports the state of every buffer to the host and raises an interrupt when there is something new to look at. It follows each buffer's valid flag and marks a buffer full when that flag rises. When the host issues a status read, the unit replies with one completion word that packs the state of every buffer.

The host picks a full buffer and a destination word address through a receive command. The unit then selects that buffer and opens a single write request toward the host bus. The request carries the destination address, the word count reported by the buffer, and the buffer's head word. Buffer words are popped only in cycles where the bus accepts. When the bus reports that the transfer is complete, the request closes and an interrupt follows.

Both interrupt causes share one level-and-acknowledge handshake: a buffer becoming full, and a writeback finishing. Causes are latched, so an event that arrives while an interrupt is already pending is not lost. A status read drops any cause still waiting, because the host has just seen the full picture.

Top module: `bufwb_engine`

## Requirements
- R1: A status read request (`cmd_rd`) sampled at a clock edge makes `cpl_valid` high after that edge. `cpl_valid` and `cpl_data` then hold until `host_done` is sampled high.
- R2: In `cpl_data`, buffer i owns bits [4i+3:4i]. Bits [4i+1:4i] carry that buffer's send-side state from `snd_state[2i+1:2i]`. Bits [4i+3:4i+2] carry its receive state, coded 00 empty, 01 address taken, 10 streaming, 11 full. Bits above 4*NBUF read zero.
- R3: When the valid flag of an empty buffer rises, its receive state reads full in the next status read. `irq` rises two clock edges after the edge at which the rise was sampled.
- R4: `irq` falls at the edge where it is high and `irq_ack` is sampled high. It stays low while no new cause occurs.
- R5: Several buffers whose valid flags rise in the same cycle produce exactly one interrupt, and the status word shows all of them full.
- R6: A cause that arrives while `irq` is high is latched. After the acknowledge, `irq` rises again at the next edge.
- R7: A status read issued while a cause is latched discards that cause, so no further interrupt follows the acknowledge.
- R8: A receive command is `cmd_wr` with `cmd_op` = 2'b10. `buf_sel` shows `cmd_buf` two edges after the command is sampled, and the buffer reads 01 in between. `cmd_wr` with any other `cmd_op` value has no effect.
- R9: One edge after `buf_sel` changes, `wr_req` rises with `wr_addr` = `cmd_addr`, `wr_len` = `buf_len`, and `wr_data` showing the buffer's head word. All of these hold until the bus accepts.
- R10: `buf_pop` is high only in cycles where `wr_req` and `host_accept` are both high, at most `wr_len` times per request. `wr_data` advances one word per pop.
- R11: `host_done` sampled during the request drops `wr_req` at that edge and returns the buffer to empty. `irq` rises one edge later.
- R12: A receive command arriving while a writeback is in progress is ignored: no new selection, no second request, and no change to the named buffer's state.
- R13: When a completion and a write request are both open, `host_done` closes the completion first and leaves the write request open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_valid | input | NBUF | Per-buffer data-present flags |
| snd_state | input | 2*NBUF | Per-buffer send-side state codes, reported in status |
| buf_sel | output | IDXW | Index of the buffer being drained |
| buf_pop | output | 1 | Consume the head word of the selected buffer |
| buf_word | input | DW | Head word of the selected buffer |
| buf_len | input | LW | Word count of the selected buffer |
| cmd_rd | input | 1 | Host status read request |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_op | input | 2 | Command code; 2'b10 is a receive command |
| cmd_buf | input | IDXW | Buffer named by the command |
| cmd_addr | input | AW | Host destination word address |
| cpl_valid | output | 1 | Status completion pending |
| cpl_data | output | DW | Packed status word |
| wr_req | output | 1 | Host write request open |
| wr_addr | output | AW | Host write word address |
| wr_len | output | LW | Host write word count |
| wr_data | output | DW | Current write data word |
| host_accept | input | 1 | Bus takes a data word this cycle |
| host_done | input | 1 | Bus finished the open completion or write |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledged |

## Verification
The writeback path is driven with a three-word buffer whose words differ. The first word is held for two cycles with accept low, which separates holding the head word from advancing it. A status read and a second receive command are then issued in the middle of the transfer. The read shows whether a shared done signal closes the completion before the write, and the second command shows that a busy unit ignores it. Accept is then kept high beyond the word count, so a pop past the length is seen directly. Interrupts are tried with a single rise, with two simultaneous rises, with a rise during a pending interrupt, and with the same rise followed by a status read. The last two runs separate latching a cause from discarding it.

// File: rtl/bufwb_pkg.sv
package bufwb_pkg;

  typedef enum logic [1:0] {
    RX_EMPTY = 2'b00,
    RX_ADDR  = 2'b01,
    RX_DATA  = 2'b10,
    RX_FULL  = 2'b11
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SEL,
    PH_LOAD,
    PH_XFER
  } wb_phase_e;

  localparam logic [1:0] OP_RECV = 2'b10;

endpackage

// File: rtl/bufwb_slots.sv
module bufwb_slots
  import bufwb_pkg::*;
#(
  parameter int NBUF = 16,
  localparam int IDXW = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBUF-1:0]   buf_valid,
  input  logic              claim_vld,
  input  logic [IDXW-1:0]   claim_idx,
  input  logic              start_vld,
  input  logic              fin_vld,
  input  logic [IDXW-1:0]   act_idx,
  output logic [2*NBUF-1:0] rx_states,
  output logic              new_ev
);

  logic [NBUF-1:0] valid_q;
  logic [NBUF-1:0] rise_ok;
  logic [NBUF-1:0] busy;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= buf_valid;
  end

  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_slot
      rx_state_e st;
      logic      hit_claim;
      logic      hit_act;

      assign hit_claim = claim_vld && (claim_idx == IDXW'(i));
      assign hit_act   = (act_idx == IDXW'(i));
      assign rise_ok[i] = buf_valid[i] && !valid_q[i] && (st == RX_EMPTY) && !hit_claim;

      always_ff @(posedge clk) begin
        if (rst)                       st <= RX_EMPTY;
        else if (hit_claim)            st <= RX_ADDR;
        else if (start_vld && hit_act) st <= RX_DATA;
        else if (fin_vld && hit_act)   st <= RX_EMPTY;
        else if (rise_ok[i])           st <= RX_FULL;
      end

      assign rx_states[2*i +: 2] = st;
      assign busy[i] = (st == RX_ADDR) || (st == RX_DATA);
    end
  endgenerate

  assign new_ev = |rise_ok;

  // R12: at most one buffer is ever claimed or streaming
  assert_single_active_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy));

endmodule

// File: rtl/bufwb_irq.sv
module bufwb_irq (
  input  logic clk,
  input  logic rst,
  input  logic new_ev,
  input  logic done_ev,
  input  logic status_rd,
  input  logic irq_ack,
  output logic irq
);

  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (irq && irq_ack)    irq <= 1'b0;
      else if (!irq && pend) irq <= 1'b1;

      if (new_ev || done_ev)              pend <= 1'b1;
      else if (status_rd || (!irq && pend)) pend <= 1'b0;
    end
  end

  // R4: acknowledge always lowers the request
  assert_irq_ack_R4: assert property (@(posedge clk) disable iff (rst)
    irq && irq_ack |=> !irq);

  // R4: without a latched cause the request cannot rise
  assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !irq && !pend |=> !irq);

endmodule

// File: rtl/bufwb_status.sv
module bufwb_status #(
  parameter int NBUF = 16,
  parameter int DW   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd,
  input  logic              host_done,
  input  logic [2*NBUF-1:0] rx_states,
  input  logic [2*NBUF-1:0] snd_states,
  output logic              cpl_valid,
  output logic [DW-1:0]     cpl_data
);

  localparam int USED = 4*NBUF;

  logic [DW-1:0] snap;

  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_pack
      assign snap[4*i +: 4] = {rx_states[2*i +: 2], snd_states[2*i +: 2]};
    end
    if (DW > USED) begin : g_pad
      assign snap[DW-1:USED] = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid <= 1'b0;
      cpl_data  <= '0;
    end else if (cmd_rd) begin
      cpl_valid <= 1'b1;
      cpl_data  <= snap;
    end else if (host_done) begin
      cpl_valid <= 1'b0;
    end
  end

  // R1: a read request always opens a completion
  assert_cpl_open_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_rd |=> cpl_valid);

  // R1: an open completion is stable until done
  assert_cpl_hold_R1: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !host_done && !cmd_rd |=> cpl_valid && $stable(cpl_data));

endmodule

// File: rtl/bufwb_stream.sv
module bufwb_stream
  import bufwb_pkg::*;
#(
  parameter int NBUF = 16,
  parameter int AW   = 48,
  parameter int LW   = 9,
  localparam int IDXW = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr,
  input  logic [1:0]      cmd_op,
  input  logic [IDXW-1:0] cmd_buf,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [LW-1:0]   buf_len,
  input  logic            host_accept,
  input  logic            host_done,
  input  logic            cpl_busy,
  output logic [IDXW-1:0] buf_sel,
  output logic            buf_pop,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [LW-1:0]   wr_len,
  output logic            claim_vld,
  output logic [IDXW-1:0] claim_idx,
  output logic            start_vld,
  output logic            fin_vld,
  output logic [IDXW-1:0] act_idx
);

  wb_phase_e       ph;
  logic [IDXW-1:0] idx_q;
  logic [LW-1:0]   left;

  assign claim_vld = (ph == PH_IDLE) && cmd_wr && (cmd_op == OP_RECV);
  assign claim_idx = cmd_buf;
  assign start_vld = (ph == PH_LOAD);
  assign fin_vld   = (ph == PH_XFER) && host_done && !cpl_busy;
  assign act_idx   = idx_q;
  assign buf_pop   = (ph == PH_XFER) && host_accept && (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      idx_q   <= '0;
      buf_sel <= '0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_len  <= '0;
      left    <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (claim_vld) begin
          idx_q   <= cmd_buf;
          wr_addr <= cmd_addr;
          ph      <= PH_SEL;
        end
        PH_SEL: begin
          buf_sel <= idx_q;
          ph      <= PH_LOAD;
        end
        PH_LOAD: begin
          wr_req <= 1'b1;
          wr_len <= buf_len;
          left   <= buf_len;
          ph     <= PH_XFER;
        end
        PH_XFER: begin
          if (fin_vld) begin
            wr_req <= 1'b0;
            ph     <= PH_IDLE;
          end else if (buf_pop) begin
            left <= left - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R9: request header is stable while the request is open
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    wr_req && !host_done |=> wr_req && $stable(wr_addr) && $stable(wr_len));

  // R8: the selected buffer never moves under an open request
  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> $stable(buf_sel));

  // R10: no pop without an open request
  assert_pop_in_req_R10: assert property (@(posedge clk) disable iff (rst)
    buf_pop |-> wr_req);

endmodule

// File: rtl/bufwb_engine.sv
module bufwb_engine
  import bufwb_pkg::*;
#(
  parameter int NBUF = 16,
  parameter int DW   = 64,
  parameter int AW   = 48,
  parameter int LW   = 9,
  localparam int IDXW = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBUF-1:0]   buf_valid,
  input  logic [2*NBUF-1:0] snd_state,
  output logic [IDXW-1:0]   buf_sel,
  output logic              buf_pop,
  input  logic [DW-1:0]     buf_word,
  input  logic [LW-1:0]     buf_len,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_op,
  input  logic [IDXW-1:0]   cmd_buf,
  input  logic [AW-1:0]     cmd_addr,
  output logic              cpl_valid,
  output logic [DW-1:0]     cpl_data,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [LW-1:0]     wr_len,
  output logic [DW-1:0]     wr_data,
  input  logic              host_accept,
  input  logic              host_done,
  output logic              irq,
  input  logic              irq_ack
);

  logic [2*NBUF-1:0] rx_states;
  logic              new_ev;
  logic              claim_vld;
  logic [IDXW-1:0]   claim_idx;
  logic              start_vld;
  logic              fin_vld;
  logic [IDXW-1:0]   act_idx;

  bufwb_slots #(.NBUF(NBUF)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .buf_valid (buf_valid),
    .claim_vld (claim_vld),
    .claim_idx (claim_idx),
    .start_vld (start_vld),
    .fin_vld   (fin_vld),
    .act_idx   (act_idx),
    .rx_states (rx_states),
    .new_ev    (new_ev)
  );

  bufwb_stream #(.NBUF(NBUF), .AW(AW), .LW(LW)) u_stream (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_op      (cmd_op),
    .cmd_buf     (cmd_buf),
    .cmd_addr    (cmd_addr),
    .buf_len     (buf_len),
    .host_accept (host_accept),
    .host_done   (host_done),
    .cpl_busy    (cpl_valid),
    .buf_sel     (buf_sel),
    .buf_pop     (buf_pop),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_len      (wr_len),
    .claim_vld   (claim_vld),
    .claim_idx   (claim_idx),
    .start_vld   (start_vld),
    .fin_vld     (fin_vld),
    .act_idx     (act_idx)
  );

  bufwb_status #(.NBUF(NBUF), .DW(DW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .cmd_rd     (cmd_rd),
    .host_done  (host_done),
    .rx_states  (rx_states),
    .snd_states (snd_state),
    .cpl_valid  (cpl_valid),
    .cpl_data   (cpl_data)
  );

  bufwb_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .new_ev    (new_ev),
    .done_ev   (fin_vld),
    .status_rd (cmd_rd),
    .irq_ack   (irq_ack),
    .irq       (irq)
  );

  // Head word of the selected buffer goes straight to the bus
  assign wr_data = buf_word;

endmodule

// File: tb/bufwb_engine_test.sv
module bufwb_engine_test;

  localparam int NBUF = 16;
  localparam int DW   = 64;
  localparam int AW   = 48;
  localparam int LW   = 9;

  logic              clk = 1'b0;
  logic              rst;
  logic [NBUF-1:0]   buf_valid;
  logic [2*NBUF-1:0] snd_state;
  logic [3:0]        buf_sel;
  logic              buf_pop;
  logic [DW-1:0]     buf_word;
  logic [LW-1:0]     buf_len;
  logic              cmd_rd, cmd_wr;
  logic [1:0]        cmd_op;
  logic [3:0]        cmd_buf;
  logic [AW-1:0]     cmd_addr;
  logic              cpl_valid;
  logic [DW-1:0]     cpl_data;
  logic              wr_req;
  logic [AW-1:0]     wr_addr;
  logic [LW-1:0]     wr_len;
  logic [DW-1:0]     wr_data;
  logic              host_accept, host_done;
  logic              irq, irq_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [1:0]  exp_rx [NBUF];
  logic [63:0] words [4];
  logic [2:0]  head;
  logic        head_clr;
  int          pop_cnt;

  always #5 clk = ~clk;

  bufwb_engine uut (
    .clk(clk), .rst(rst), .buf_valid(buf_valid), .snd_state(snd_state),
    .buf_sel(buf_sel), .buf_pop(buf_pop), .buf_word(buf_word), .buf_len(buf_len),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_buf(cmd_buf),
    .cmd_addr(cmd_addr), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .host_accept(host_accept), .host_done(host_done), .irq(irq), .irq_ack(irq_ack)
  );

  // Buffer model: head word shown, advanced by each pop
  assign buf_word = head[2] ? 64'd0 : words[head[1:0]];
  always @(posedge clk) begin
    if (head_clr) begin
      head    <= 3'd0;
      pop_cnt <= 0;
    end else if (buf_pop) begin
      head    <= head + 3'd1;
      pop_cnt <= pop_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word();
    logic [63:0] w = '0;
    for (int i = 0; i < NBUF; i++) w[4*i +: 4] = {exp_rx[i], snd_state[2*i +: 2]};
    return w;
  endfunction

  task automatic do_status(input string tag);
    cmd_rd = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0;
    chk({tag, " cpl_valid"}, cpl_valid, 1);
    chk({tag, " status word"}, cpl_data, exp_word());
    host_done = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    chk({tag, " cpl closed"}, cpl_valid, 0);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("reset R1 cpl_valid", cpl_valid, 0);
    chk("reset R11 wr_req", wr_req, 0);
    chk("reset R4 irq", irq, 0);
    chk("reset R8 buf_sel", buf_sel, 0);
    chk("reset R10 buf_pop", buf_pop, 0);
  endtask

  task automatic t_status();
    logic [63:0] first;
    snd_state[2*2 +: 2]  = 2'b10;
    snd_state[2*7 +: 2]  = 2'b01;
    snd_state[2*15 +: 2] = 2'b11;
    cmd_rd = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0;
    chk("R1 completion one cycle after read", cpl_valid, 1);
    chk("R2 packed layout", cpl_data, exp_word());
    first = cpl_data;
    @(negedge clk);
    chk("R1 completion held", cpl_valid, 1);
    chk("R1 data held", cpl_data, first);
    host_done = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    chk("R1 closed by done", cpl_valid, 0);
  endtask

  task automatic t_valid_irq();
    buf_valid[5] = 1'b1;
    @(negedge clk);
    chk("R3 irq not yet", irq, 0);
    @(negedge clk);
    chk("R3 irq two cycles after rise", irq, 1);
    exp_rx[5] = 2'b11;
    do_status("R3 full shown");
    chk("R4 irq waits for ack", irq, 1);
    do_ack();
    chk("R4 irq dropped on ack", irq, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 irq stays low", irq, 0);
    end
  endtask

  task automatic t_multi();
    buf_valid[1] = 1'b1;
    buf_valid[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 single irq raised", irq, 1);
    do_ack();
    chk("R5 irq dropped", irq, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 no second irq", irq, 0);
    end
    exp_rx[1] = 2'b11;
    exp_rx[3] = 2'b11;
    do_status("R5 both full");
  endtask

  task automatic t_latch();
    buf_valid[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 first irq", irq, 1);
    buf_valid[10] = 1'b1;
    @(negedge clk);
    do_ack();
    chk("R6 irq dropped on ack", irq, 0);
    @(negedge clk);
    chk("R6 latched cause re-raises irq", irq, 1);
    do_ack();
    chk("R6 second ack", irq, 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R6 quiet after", irq, 0);
    end
    exp_rx[9]  = 2'b11;
    exp_rx[10] = 2'b11;
  endtask

  task automatic t_cancel();
    buf_valid[11] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 irq raised", irq, 1);
    buf_valid[12] = 1'b1;
    @(negedge clk);
    exp_rx[11] = 2'b11;
    exp_rx[12] = 2'b11;
    do_status("R7 status shows both");
    do_ack();
    chk("R7 irq dropped", irq, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 discarded cause gives no irq", irq, 0);
    end
  endtask

  task automatic t_ignore_op();
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      cmd_wr   = 1'b1;
      cmd_op   = 2'(op);
      cmd_buf  = 4'd4;
      cmd_addr = 48'h777;
      @(negedge clk);
      cmd_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R8 other op leaves sel", buf_sel, 0);
      chk("R8 other op no request", wr_req, 0);
    end
    do_status("R8 buffer 4 untouched");
  endtask

  task automatic t_recv();
    buf_len  = 9'd3;
    head_clr = 1'b1;
    @(negedge clk);
    head_clr = 1'b0;
    cmd_wr   = 1'b1;
    cmd_op   = 2'b10;
    cmd_buf  = 4'd5;
    cmd_addr = 48'h0000_1234_5678;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R8 sel not yet", buf_sel, 0);
    chk("R9 no request yet", wr_req, 0);
    cmd_rd = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0;
    chk("R8 sel two cycles after command", buf_sel, 5);
    chk("R8 address-taken code", cpl_data[23:22], 2'b01);
    chk("R9 request not before sel+1", wr_req, 0);
    host_done = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    chk("R9 request raised", wr_req, 1);
    chk("R9 address", wr_addr, 48'h0000_1234_5678);
    chk("R9 length", wr_len, 3);
    chk("R9 first word", wr_data, words[0]);
    chk("R10 no pop without accept", buf_pop, 0);
    @(negedge clk);
    chk("R9 word held", wr_data, words[0]);
    chk("R9 request held", wr_req, 1);
    cmd_wr   = 1'b1;
    cmd_op   = 2'b10;
    cmd_buf  = 4'd7;
    cmd_addr = 48'h999;
    cmd_rd   = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    cmd_rd = 1'b0;
    exp_rx[5] = 2'b10;
    chk("R13 completion open", cpl_valid, 1);
    chk("R13 request open", wr_req, 1);
    chk("R2 streaming code and R12 buffer 7 empty", cpl_data, exp_word());
    host_done = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    chk("R13 completion closed first", cpl_valid, 0);
    chk("R13 request kept", wr_req, 1);
    chk("R12 sel unchanged", buf_sel, 5);
    chk("R12 address unchanged", wr_addr, 48'h0000_1234_5678);
    host_accept = 1'b1;
    #1;
    chk("R10 pop with accept", buf_pop, 1);
    chk("R10 word 0", wr_data, words[0]);
    @(negedge clk);
    chk("R10 pop continues", buf_pop, 1);
    chk("R10 word 1", wr_data, words[1]);
    @(negedge clk);
    chk("R10 word 2", wr_data, words[2]);
    @(negedge clk);
    chk("R10 no pop past length", buf_pop, 0);
    chk("R10 pop count", pop_cnt, 3);
    host_accept = 1'b0;
    host_done   = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    chk("R11 request dropped", wr_req, 0);
    chk("R11 irq not yet", irq, 0);
    @(negedge clk);
    chk("R11 irq after writeback", irq, 1);
    do_ack();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 no second request", wr_req, 0);
    end
    exp_rx[5] = 2'b00;
    do_status("R11 buffer emptied");
  endtask

  initial begin
    rst = 1'b1;
    buf_valid = '0; snd_state = '0; buf_len = '0;
    cmd_rd = 0; cmd_wr = 0; cmd_op = 0; cmd_buf = 0; cmd_addr = '0;
    host_accept = 0; host_done = 0; irq_ack = 0; head_clr = 1'b1;
    for (int i = 0; i < NBUF; i++) exp_rx[i] = 2'b00;
    words[0] = 64'hA0A0_1111_2222_3333;
    words[1] = 64'hB1B1_4444_5555_6666;
    words[2] = 64'hC2C2_7777_8888_9999;
    words[3] = 64'hD3D3_AAAA_BBBB_CCCC;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    head_clr = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_valid_irq();
    t_multi();
    t_latch();
    t_cancel();
    t_ignore_op();
    t_recv();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule